// File: doc/BRIEF.md
# Converter Bring-Up and Sample Capture Sequencer

This block sits on the host side of a self-calibrating pipelined analog-to-digital converter and runs in the converter's clock domain. It steps the converter through a fixed order of events before any sample is used. First it waits a programmable number of cycles so that the reference outputs can settle. It then raises the converter's reset line for a fixed pulse, raises the calibrate line for a fixed pulse, and waits out the calibration time. Finally it discards the output words of the pipeline flush period. The converter's output bus is enabled only after all of this. From then on, each word the converter marks as valid with its active-low end-of-conversion flag is captured on the rising clock edge and presented as a valid/data pair.

Two events restart the order. A power-down request drives the converter's active-low power control low at once. Releasing the request restarts the whole sequence, settling included, because pipeline contents and calibration are both lost. While the block is running, it also compares a signed temperature input with the value it stored when the last calibration began. When the two are more than 50 degrees apart, in either direction, it repeats the reset and calibrate steps without the settling wait.

Top module: `adc_bringup_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `conv_rst_o`=0, `conv_cal_o`=0, `conv_pwr_n_o`=1, `conv_rd_n_o`=1 and `smp_valid_o`=0.
- R2: After `rst_n` is released, `conv_rst_o` first reads high after exactly `SETTLE_CYC` rising edges, and `conv_cal_o` stays low before that.
- R3: `conv_rst_o` stays high for exactly `PULSE_CYC` cycles (at least 2). `conv_cal_o` then goes high on the next cycle and stays high for exactly `PULSE_CYC` cycles. The two are never high together.
- R4: After `conv_cal_o` falls, `conv_rd_n_o` stays high for exactly `CAL_CYC + BLANK_CYC` cycles and then goes low.
- R5: While `conv_rd_n_o` is low, a rising edge with `eoc_n_i`=0 makes `smp_valid_o`=1 and `smp_data_o` equal to the `adc_data_i` seen at that edge on the following cycle. An edge with `eoc_n_i`=1 gives `smp_valid_o`=0.
- R6: `smp_valid_o` is 0 whenever `conv_rd_n_o` is high (settle, reset, calibrate, blanking, power-down), whatever `eoc_n_i` does.
- R7: `pd_req_i`=1 at a rising edge, in any state, gives `conv_pwr_n_o`=0, `conv_rst_o`=0, `conv_cal_o`=0, `conv_rd_n_o`=1 and `smp_valid_o`=0 after that edge. These values hold for as long as the request stays high.
- R8: Once `pd_req_i` falls, `conv_pwr_n_o` returns high after the next edge. `conv_rst_o` first reads high after `SETTLE_CYC + 1` edges, and the whole R3/R4 sequence follows.
- R9: `temp_i` (8-bit two's complement, degrees) is stored when a calibrate pulse starts. While running, an absolute difference above 50 from the stored value raises `conv_rst_o` after the next edge, with no settle wait, and the R3/R4 sequence follows. A difference of exactly 50 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all logic on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_i | input | 8 | Signed temperature in degrees |
| pd_req_i | input | 1 | Power-down request, active high |
| eoc_n_i | input | 1 | Converter end-of-conversion flag, low when a word is valid |
| adc_data_i | input | 16 | Converter output word, two's complement |
| conv_rst_o | output | 1 | Converter reset line, active high |
| conv_cal_o | output | 1 | Converter calibrate line, active high |
| conv_pwr_n_o | output | 1 | Converter power control, low powers it down |
| conv_rd_n_o | output | 1 | Converter output enable, active low |
| smp_valid_o | output | 1 | Captured word valid |
| smp_data_o | output | 16 | Captured word |

## Verification
The bench measures each phase length cycle by cycle: settle, reset pulse, calibrate pulse and the combined calibration and blanking gap. An off-by-one counter would shorten a pulse below the converter's two-cycle minimum, or let flush garbage through. It holds `eoc_n_i` low through the whole bring-up so that a block that opened the output bus early would show stray valid words. The drift table steps the temperature to exactly 50 and to 51 degrees away, on both sides and at the signed extremes. A comparator with the wrong sign, the wrong width or `>=` instead of `>` would recalibrate too often or not at all. Power-down is requested both while running and in the middle of a calibrate pulse, and a design that skipped the settle wait on recovery would raise reset one settle period early.

// File: rtl/adc_seq_pkg.sv
// Shared types for the converter bring-up sequencer.
// Assumes: one clock domain, states encoded in three bits.
package adc_seq_pkg;

    // Sequencer phases, in bring-up order, plus power-down.
    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,
        ST_RESET  = 3'd1,
        ST_CALP   = 3'd2,
        ST_CALW   = 3'd3,
        ST_BLANK  = 3'd4,
        ST_RUN    = 3'd5,
        ST_PWRDN  = 3'd6
    } seq_state_t;

    // Larger of two phase lengths, used to size the phase counter.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Phase counter: counts cycles spent in the current timed phase.
// done_o is high in the last cycle of a phase of len_i cycles.
// Assumes: len_i >= 1, restart_i pulses on every phase change.
module seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Clear on phase entry, otherwise count while the phase is timed.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (run_i)     cnt_q <= cnt_q + CNT_W'(1);
    end

    // Last-cycle flag of the current phase.
    always_comb done_o = run_i && (cnt_q == len_i - CNT_W'(1));

    // A timed phase never runs past its length.
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < len_i));
endmodule

// File: rtl/drift_monitor.sv
// Temperature drift monitor: stores the temperature when a calibration
// starts and flags an absolute difference above LIMIT.
// Assumes: temperatures are two's complement of TEMP_W bits.
module drift_monitor #(
    parameter int TEMP_W = 8,
    parameter int LIMIT  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              drift_o
);
    localparam int DW = TEMP_W + 1;

    logic [TEMP_W-1:0] ref_q;
    logic [DW-1:0]     diff;
    logic [DW-1:0]     mag;

    // Capture the calibration temperature.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= '0;
        else if (snap_i) ref_q <= temp_i;
    end

    // Sign-extended difference, its magnitude and the threshold compare.
    always_comb begin
        diff    = {temp_i[TEMP_W-1], temp_i} - {ref_q[TEMP_W-1], ref_q};
        mag     = diff[DW-1] ? (~diff + DW'(1)) : diff;
        drift_o = (mag > DW'(LIMIT));
    end
endmodule

// File: rtl/sample_capture.sv
// Output capture: registers a converter word when take_i is set and the
// end-of-conversion flag is low; holds the last word otherwise.
// Assumes: eoc_n_i and data_i are stable around the rising edge.
module sample_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    logic hit;

    // A word is accepted only in the running phase with EOC asserted.
    always_comb hit = take_i && !eoc_n_i;

    // Valid flag and word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= hit;
            if (hit) data_o <= data_i;
        end
    end
endmodule

// File: rtl/adc_bringup_seq.sv
// Converter bring-up and capture sequencer (top).
// Orders settle -> reset pulse -> calibrate pulse -> calibration wait ->
// blanking -> run; restarts on power-down exit (with settle) or on
// temperature drift (without settle). Control lines are registered.
// Assumes: PULSE_CYC >= 2, all phase lengths >= 1.
module adc_bringup_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int TEMP_W     = 8,
    parameter int SETTLE_CYC = 250000,
    parameter int PULSE_CYC  = 2,
    parameter int CAL_CYC    = 272800,
    parameter int BLANK_CYC  = 13,
    parameter int DRIFT_LIM  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              pd_req_i,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              conv_rst_o,
    output logic              conv_cal_o,
    output logic              conv_pwr_n_o,
    output logic              conv_rd_n_o,
    output logic              smp_valid_o,
    output logic [DATA_W-1:0] smp_data_o
);
    localparam int MAX_LEN = max2(max2(SETTLE_CYC, PULSE_CYC), max2(CAL_CYC, BLANK_CYC));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_t       state_q, state_d;
    logic             timed, phase_done, restart, snap, take, drift;
    logic [CNT_W-1:0] phase_len;

    // Phase length for the current state.
    always_comb begin
        timed = 1'b1;
        unique case (state_q)
            ST_SETTLE: phase_len = CNT_W'(SETTLE_CYC);
            ST_RESET:  phase_len = CNT_W'(PULSE_CYC);
            ST_CALP:   phase_len = CNT_W'(PULSE_CYC);
            ST_CALW:   phase_len = CNT_W'(CAL_CYC);
            ST_BLANK:  phase_len = CNT_W'(BLANK_CYC);
            default: begin
                phase_len = CNT_W'(1);
                timed     = 1'b0;
            end
        endcase
    end

    // Next-state choice; power-down request wins over everything.
    always_comb begin
        state_d = state_q;
        if (pd_req_i) begin
            state_d = ST_PWRDN;
        end else begin
            unique case (state_q)
                ST_PWRDN:  state_d = ST_SETTLE;
                ST_SETTLE: if (phase_done) state_d = ST_RESET;
                ST_RESET:  if (phase_done) state_d = ST_CALP;
                ST_CALP:   if (phase_done) state_d = ST_CALW;
                ST_CALW:   if (phase_done) state_d = ST_BLANK;
                ST_BLANK:  if (phase_done) state_d = ST_RUN;
                ST_RUN:    if (drift)      state_d = ST_RESET;
                default:   state_d = ST_SETTLE;
            endcase
        end
    end

    // Phase-change and capture qualifiers.
    always_comb begin
        restart = (state_d != state_q);
        snap    = (state_d == ST_CALP) && (state_q != ST_CALP);
        take    = (state_q == ST_RUN) && (state_d == ST_RUN);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SETTLE;
        else        state_q <= state_d;
    end

    // Registered converter control lines, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_rst_o   <= 1'b0;
            conv_cal_o   <= 1'b0;
            conv_pwr_n_o <= 1'b1;
            conv_rd_n_o  <= 1'b1;
        end else begin
            conv_rst_o   <= (state_d == ST_RESET);
            conv_cal_o   <= (state_d == ST_CALP);
            conv_pwr_n_o <= (state_d != ST_PWRDN);
            conv_rd_n_o  <= (state_d != ST_RUN);
        end
    end

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (timed),
        .len_i     (phase_len),
        .done_o    (phase_done)
    );

    drift_monitor #(.TEMP_W(TEMP_W), .LIMIT(DRIFT_LIM)) u_drift (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_i  (snap),
        .temp_i  (temp_i),
        .drift_o (drift)
    );

    sample_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .eoc_n_i (eoc_n_i),
        .data_i  (adc_data_i),
        .valid_o (smp_valid_o),
        .data_o  (smp_data_o)
    );

    // Reset and calibrate pulses never overlap.
    assert_rst_cal_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_rst_o && conv_cal_o));

    // Calibrate pulse starts straight after a reset pulse.
    assert_cal_after_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_cal_o) |-> $past(conv_rst_o));

    // Reset pulse lasts at least two cycles.
    assert_rst_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_rst_o) |-> ($past(conv_rst_o) && $past(conv_rst_o, 2)));

    // A captured word only appears while the output bus is enabled.
    assert_valid_needs_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> !conv_rd_n_o);

    // A captured word follows an asserted end-of-conversion flag.
    assert_valid_after_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> !$past(eoc_n_i));

    // A power-down request takes effect on the next cycle.
    assert_pd_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req_i |=> !conv_pwr_n_o);

    // Power-down keeps all other control lines quiet.
    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_pwr_n_o |-> (!conv_rst_o && !conv_cal_o && conv_rd_n_o));

    // A reset pulse that interrupts the running phase is caused by drift.
    assert_drift_recal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_rst_o) && $past(!conv_rd_n_o)) |-> $past(drift));
endmodule

// File: tb/adc_bringup_seq_tb.sv
`timescale 1ns/1ps
module adc_bringup_seq_tb;
    localparam int SETTLE = 20;
    localparam int PULSE  = 2;
    localparam int CAL    = 300;
    localparam int BLANK  = 13;

    // Drift table: temperature applied while running, and whether a
    // recalibration is expected (reference starts at 20 and follows recals).
    localparam int NDRIFT = 9;
    localparam int DRIFT_T   [NDRIFT] = '{70, -30, 71, 121, 122, 127, -128, -78, -77};
    localparam bit DRIFT_EXP [NDRIFT] = '{0, 0, 1, 0, 1, 0, 1, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  temp_i;
    logic        pd_req_i;
    logic        eoc_n_i;
    logic [15:0] adc_data_i;
    logic        conv_rst_o, conv_cal_o, conv_pwr_n_o, conv_rd_n_o, smp_valid_o;
    logic [15:0] smp_data_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_bringup_seq #(
        .SETTLE_CYC (SETTLE),
        .PULSE_CYC  (PULSE),
        .CAL_CYC    (CAL),
        .BLANK_CYC  (BLANK)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_i       (temp_i),
        .pd_req_i     (pd_req_i),
        .eoc_n_i      (eoc_n_i),
        .adc_data_i   (adc_data_i),
        .conv_rst_o   (conv_rst_o),
        .conv_cal_o   (conv_cal_o),
        .conv_pwr_n_o (conv_pwr_n_o),
        .conv_rd_n_o  (conv_rd_n_o),
        .smp_valid_o  (smp_valid_o),
        .smp_data_o   (smp_data_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 60000 && !finished) begin
            finished = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 60000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_idle_values(input string tag);
        chk(conv_rst_o == 1'b0,   {tag, " conv_rst_o"},   conv_rst_o,   0);
        chk(conv_cal_o == 1'b0,   {tag, " conv_cal_o"},   conv_cal_o,   0);
        chk(conv_pwr_n_o == 1'b1, {tag, " conv_pwr_n_o"}, conv_pwr_n_o, 1);
        chk(conv_rd_n_o == 1'b1,  {tag, " conv_rd_n_o"},  conv_rd_n_o,  1);
        chk(smp_valid_o == 1'b0,  {tag, " smp_valid_o"},  smp_valid_o,  0);
    endtask

    // Walk one bring-up sequence; eoc_n_i is held low to expose early capture.
    task automatic run_sequence(input int settle_exp, input string tag);
        int n = 0;
        int w = 0;
        int c = 0;
        int g = 0;
        int early_cal = 0;
        int stray = 0;
        eoc_n_i = 1'b0;
        do begin
            tick();
            n++;
            if (!conv_rst_o && conv_cal_o) early_cal++;
        end while (!conv_rst_o && n < 2000);
        chk(n == settle_exp, {tag, " cycles until reset pulse"}, n, settle_exp);
        chk(early_cal == 0, {tag, " calibrate before reset"}, early_cal, 0);
        while (conv_rst_o && w < 100) begin
            if (conv_cal_o) stray++;
            w++;
            tick();
        end
        chk(w == PULSE, "R3 reset pulse width", w, PULSE);
        chk(conv_cal_o == 1'b1, "R3 calibrate follows reset", conv_cal_o, 1);
        while (conv_cal_o && c < 100) begin
            if (conv_rst_o) stray++;
            c++;
            tick();
        end
        chk(c == PULSE, "R3 calibrate pulse width", c, PULSE);
        while (conv_rd_n_o && g < 5000) begin
            if (smp_valid_o) stray++;
            g++;
            tick();
        end
        chk(g == CAL + BLANK, "R4 calibration plus blanking gap", g, CAL + BLANK);
        chk(stray == 0, "R6 no capture or overlap during bring-up", stray, 0);
        eoc_n_i = 1'b1;
    endtask

    initial begin
        int ref_t;
        rst_n      = 1'b0;
        pd_req_i   = 1'b0;
        eoc_n_i    = 1'b1;
        adc_data_i = 16'h0000;
        temp_i     = 8'd20;
        ref_t      = 20;
        repeat (4) tick();
        chk_idle_values("R1 in reset");

        // Initial bring-up.
        rst_n = 1'b1;
        run_sequence(SETTLE, "R2 initial");

        // Capture patterns, including the signed extremes.
        for (int i = 0; i < 8; i++) begin
            logic [15:0] word;
            logic        fl;
            word = 16'(32'h5A3C + i * 32'h1357);
            if (i == 3) word = 16'h8000;
            if (i == 5) word = 16'h7FFF;
            fl = (i % 3 == 2);
            eoc_n_i    = fl;
            adc_data_i = word;
            tick();
            chk(smp_valid_o == !fl, "R5 valid follows eoc_n", smp_valid_o, !fl);
            if (!fl) chk(smp_data_o == word, "R5 captured word", smp_data_o, word);
        end
        eoc_n_i = 1'b1;

        // Drift table walk.
        for (int i = 0; i < NDRIFT; i++) begin
            int d;
            temp_i = 8'(DRIFT_T[i]);
            d = DRIFT_T[i] - ref_t;
            if (d < 0) d = -d;
            chk((d > 50) == DRIFT_EXP[i], "R9 table consistency", d, 50);
            if (DRIFT_EXP[i]) begin
                run_sequence(1, "R9 drift recalibration");
                ref_t = DRIFT_T[i];
            end else begin
                int bad = 0;
                repeat (3) begin
                    tick();
                    if (conv_rst_o || conv_rd_n_o) bad++;
                end
                chk(bad == 0, "R9 drift of 50 ignored", bad, 0);
            end
        end

        // Power-down while running.
        eoc_n_i  = 1'b0;
        pd_req_i = 1'b1;
        tick();
        chk(conv_pwr_n_o == 1'b0, "R7 power-down asserted", conv_pwr_n_o, 0);
        chk(conv_rd_n_o == 1'b1, "R7 output bus disabled", conv_rd_n_o, 1);
        begin
            int bad = 0;
            repeat (5) begin
                tick();
                if (smp_valid_o || conv_rst_o || conv_cal_o || conv_pwr_n_o) bad++;
            end
            chk(bad == 0, "R7 quiet during power-down", bad, 0);
        end
        pd_req_i = 1'b0;
        tick();
        chk(conv_pwr_n_o == 1'b1, "R8 power restored", conv_pwr_n_o, 1);
        run_sequence(SETTLE, "R8 after power-down");

        // Power-down in the middle of a calibrate pulse.
        pd_req_i = 1'b1;
        tick();
        pd_req_i = 1'b0;
        begin
            int n = 0;
            while (!conv_cal_o && n < 200) begin
                tick();
                n++;
            end
        end
        pd_req_i = 1'b1;
        tick();
        chk(conv_cal_o == 1'b0, "R7 calibrate dropped on power-down", conv_cal_o, 0);
        chk(conv_pwr_n_o == 1'b0, "R7 power-down during calibrate", conv_pwr_n_o, 0);
        pd_req_i = 1'b0;
        run_sequence(SETTLE + 1, "R8 recovery from mid-calibrate");

        // Reset in the middle of running.
        rst_n = 1'b0;
        tick();
        chk_idle_values("R1 reset while running");
        rst_n = 1'b1;
        tick();
        chk_idle_values("R1 first cycle after reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule